// File: doc/BRIEF.md
# Oscillator-Swept Chorus Delay Core

This block adds a chorus to a mono stream of signed PCM audio samples. Each time a sample arrives it is used twice. One copy (dry) passes straight through. The other copy (wet) is written into a circular delay memory. The wet sample that comes back out is read from a tap that trails the write position. A slow sine oscillator keeps moving that tap, so the delay rises and falls over time. The dry sample and the delayed wet sample are then averaged into one output sample.

The block does one memory write and one memory read per input strobe. At the nominal audio rate this is one strobe every few hundred system clocks, but strobes may also come on back-to-back cycles. A speed input sets how many samples pass between oscillator steps, which sets the sweep rate of the delay. The block also provides:
- the undelayed input sample, aligned with the mixed output, for debug;
- a one-cycle pulse each time the oscillator moves to a new table entry.

Top module: `chorus_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, out_valid and lfo_tick are 0 and out_mix and out_dry are 0.
- R2: Each cycle with in_valid high produces exactly one cycle with out_valid high, two clock edges later. With in_valid low, out_valid stays low.
- R3: out_mix equals (dry + wet) >>> 1. The sum is formed at 17 bits and shifted arithmetically, which rounds toward minus infinity. Full-scale inputs of either sign never wrap.
- R4: The wet sample for the n-th accepted sample (counted from 0) is the sample accepted at index n - D. D = 256 + S, where S is the oscillator table value (0..255) current when sample n is accepted.
- R5: The wet sample is 0 while n < D, that is, before D samples have been written since reset.
- R6: Oscillator table entry i (0..255) equals floor(128 + 127*sin(2*pi*i/256) + 0.5). The phase starts at entry 0 after reset.
- R7: A prescale counter counts accepted samples. When a sample is accepted with the counter at or above T = (speed_sel+1)*16 - 1, the counter returns to 0 and the phase moves to the next entry, wrapping from 255 to 0. Otherwise the counter increments.
- R8: lfo_tick is high for exactly the one cycle after the edge at which the phase moves. It is low at all other times.
- R9: out_dry equals the input sample whose result is on out_mix in the same cycle.
- R10: Cycles without in_valid change neither the write position, the prescale counter nor the phase.
- R11: The write position wraps modulo 1024. Reads at read position = write position - D modulo 1024 return correct data across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe, one cycle per sample |
| in_sample | input | 16 | Signed input sample |
| speed_sel | input | 4 | Oscillator speed; a larger value gives a slower sweep |
| out_valid | output | 1 | Mixed sample strobe |
| out_mix | output | 16 | Signed half wet, half dry result |
| out_dry | output | 16 | Undelayed sample matching out_mix |
| lfo_tick | output | 1 | Pulse when the oscillator steps |

## Verification
The bench uses a ramp of distinct values so that any error in the tap offset shows up as a wrong value. The same ramp is long enough to cross the start-up zero region and the 1024-entry pointer wrap. Long runs of positive and negative full-scale samples separate correct 17-bit averaging from a wrapped 16-bit sum and from wrong rounding. Random idle gaps between strobes, together with changes of the speed setting (including a drop below the current count), check that the counter and phase move only on accepted samples and that the terminal-count compare is correct.

// File: rtl/chorus_pkg.sv
package chorus_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // Table entry: mid-scale offset plus a rounded sine of amplitude mid-1.
   function automatic int sine_entry(input int idx, input int depth, input int width);
      real mid;
      real amp;
      real ang;
      mid = 2.0 ** (width - 1);
      amp = mid - 1.0;
      ang = TWO_PI * real'(idx) / real'(depth);
      return $rtoi($floor(mid + amp * $sin(ang) + 0.5));
   endfunction

endpackage

// File: rtl/chorus_lfo.sv
module chorus_lfo #(
   parameter int SPEED_W     = 4,
   parameter int PRESC_SHIFT = 4,
   parameter int LUT_DEPTH   = 256,
   parameter int LUT_W       = 8,
   parameter int SWING_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_en,
   input  logic [SPEED_W-1:0] speed_sel,
   output logic [SWING_W-1:0] swing,
   output logic               tick
);
   localparam int LUT_AW = $clog2(LUT_DEPTH);
   localparam int CNT_W  = SPEED_W + PRESC_SHIFT;

   if (PRESC_SHIFT < 1) begin : g_chk_presc
      $error("PRESC_SHIFT must be at least 1");
   end
   if ((1 << LUT_AW) != LUT_DEPTH) begin : g_chk_depth
      $error("LUT_DEPTH must be a power of two");
   end
   if (SWING_W > LUT_W) begin : g_chk_swing
      $error("SWING_W must not exceed LUT_W");
   end

   logic [LUT_W-1:0]  sine_rom [LUT_DEPTH];
   logic [LUT_AW-1:0] phase;
   logic [CNT_W-1:0]  presc_cnt;
   logic [CNT_W-1:0]  term_cnt;

   for (genvar i = 0; i < LUT_DEPTH; i++) begin : g_rom
      localparam int ENT = chorus_pkg::sine_entry(i, LUT_DEPTH, LUT_W);
      assign sine_rom[i] = LUT_W'(ENT);
   end

   // (speed+1) * 2**PRESC_SHIFT - 1
   assign term_cnt = {speed_sel, {PRESC_SHIFT{1'b1}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         presc_cnt <= '0;
         phase     <= '0;
         tick      <= 1'b0;
      end else if (step_en) begin
         if (presc_cnt >= term_cnt) begin
            presc_cnt <= '0;
            phase     <= phase + 1'b1;
            tick      <= 1'b1;
         end else begin
            presc_cnt <= presc_cnt + 1'b1;
            tick      <= 1'b0;
         end
      end else begin
         tick <= 1'b0;
      end
   end

   if (SWING_W == LUT_W) begin : g_swing_full
      assign swing = sine_rom[phase];
   end else begin : g_swing_trim
      logic [LUT_W-1:0] raw;
      assign raw   = sine_rom[phase];
      assign swing = raw[LUT_W-1 -: SWING_W];
   end

   // R7: a step always moves the phase by exactly one entry
   assert_phase_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (phase == LUT_AW'($past(phase) + 1'b1)));

   // R8: the step pulse never lasts two cycles
   assert_tick_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/chorus_delay_line.sv
module chorus_delay_line #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 1024
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic signed [SAMPLE_W-1:0]  wr_data,
   input  logic [$clog2(DEPTH)-1:0]    delay,
   output logic signed [SAMPLE_W-1:0]  wet
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end

   logic signed [SAMPLE_W-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_addr;
   logic [AW:0]   fill;
   logic          primed;

   assign rd_addr = wr_ptr - delay;
   assign primed  = (fill >= {1'b0, delay});

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         fill   <= '0;
         wet    <= '0;
      end else if (wr_en) begin
         wr_ptr <= wr_ptr + 1'b1;
         if (fill != (AW+1)'(DEPTH)) begin
            fill <= fill + 1'b1;
         end
         wet <= primed ? mem[rd_addr] : '0;
      end
   end

   // R4: the tap must trail the write slot, never sit on it
   assert_tap_behind_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (rd_addr != wr_ptr));

   // R11: the fill count never passes the buffer size
   assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= (AW+1)'(DEPTH));

endmodule

// File: rtl/chorus_mixer.sv
module chorus_mixer #(
   parameter int SAMPLE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mix_en,
   input  logic signed [SAMPLE_W-1:0] dry,
   input  logic signed [SAMPLE_W-1:0] wet,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_mix,
   output logic signed [SAMPLE_W-1:0] out_dry
);
   logic signed [SAMPLE_W:0] sum;

   assign sum = {dry[SAMPLE_W-1], dry} + {wet[SAMPLE_W-1], wet};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mix   <= '0;
         out_dry   <= '0;
      end else begin
         out_valid <= mix_en;
         if (mix_en) begin
            out_mix <= sum[SAMPLE_W:1];
            out_dry <= dry;
         end
      end
   end

   // R3: two non-negative inputs never give a negative blend
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_en && !dry[SAMPLE_W-1] && !wet[SAMPLE_W-1]) |=> !out_mix[SAMPLE_W-1]);

   // R3: two negative inputs never give a non-negative blend
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_en && dry[SAMPLE_W-1] && wet[SAMPLE_W-1]) |=> out_mix[SAMPLE_W-1]);

endmodule

// File: rtl/chorus_core.sv
module chorus_core #(
   parameter int SAMPLE_W    = 16,
   parameter int DEPTH       = 1024,
   parameter int BASE_DELAY  = 256,
   parameter int SPEED_W     = 4,
   parameter int PRESC_SHIFT = 4,
   parameter int LUT_DEPTH   = 256,
   parameter int LUT_W       = 8,
   parameter int SWING_W     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic [SPEED_W-1:0]  speed_sel,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_mix,
   output logic [SAMPLE_W-1:0] out_dry,
   output logic                lfo_tick
);
   localparam int AW = $clog2(DEPTH);

   if (BASE_DELAY < 1 || BASE_DELAY + (1 << SWING_W) > DEPTH) begin : g_chk_delay
      $error("BASE_DELAY plus swing range must fit inside DEPTH");
   end

   logic [SWING_W-1:0]         swing;
   logic [AW-1:0]              delay;
   logic signed [SAMPLE_W-1:0] wet;
   logic signed [SAMPLE_W-1:0] dry_q;
   logic                       stage_v;
   logic signed [SAMPLE_W-1:0] mix_s;
   logic signed [SAMPLE_W-1:0] dry_s;

   assign delay = AW'(BASE_DELAY) + AW'(swing);

   chorus_lfo #(
      .SPEED_W(SPEED_W), .PRESC_SHIFT(PRESC_SHIFT), .LUT_DEPTH(LUT_DEPTH),
      .LUT_W(LUT_W), .SWING_W(SWING_W)
   ) u_lfo (
      .clk(clk), .rst_n(rst_n), .step_en(in_valid), .speed_sel(speed_sel),
      .swing(swing), .tick(lfo_tick)
   );

   chorus_delay_line #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_dline (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(in_sample),
      .delay(delay), .wet(wet)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_v <= 1'b0;
         dry_q   <= '0;
      end else begin
         stage_v <= in_valid;
         if (in_valid) begin
            dry_q <= in_sample;
         end
      end
   end

   chorus_mixer #(.SAMPLE_W(SAMPLE_W)) u_mix (
      .clk(clk), .rst_n(rst_n), .mix_en(stage_v), .dry(dry_q), .wet(wet),
      .out_valid(out_valid), .out_mix(mix_s), .out_dry(dry_s)
   );

   assign out_mix = mix_s;
   assign out_dry = dry_s;

   // R2: every accepted sample leaves two edges later
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);

   // R9: the debug copy leaves with the same strobe as the mix
   assert_dry_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stage_v |=> (out_dry == $past(dry_q)));

endmodule

// File: tb/tb_chorus_core.sv
module tb_chorus_core;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_sample = '0;
   logic [3:0]  speed_sel = '0;
   logic        out_valid;
   logic [15:0] out_mix;
   logic [15:0] out_dry;
   logic        lfo_tick;

   int checks = 0;
   int failures = 0;
   string tag = "R1";
   bit done = 1'b0;

   chorus_core dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .speed_sel(speed_sel), .out_valid(out_valid), .out_mix(out_mix),
      .out_dry(out_dry), .lfo_tick(lfo_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Reference model
   int sine_tab [256];
   int hist [$];
   int m_cnt, m_phase;
   bit s0_v, s1_v, tick_now;
   int s0_mix, s0_dry, s1_mix, s1_dry;

   initial begin
      for (int i = 0; i < 256; i++)
         sine_tab[i] = $rtoi($floor(128.0 + 127.0 * $sin(6.283185307179586 * real'(i) / 256.0) + 0.5));
   end

   always @(posedge clk) begin
      s1_v = s0_v; s1_mix = s0_mix; s1_dry = s0_dry;
      tick_now = 1'b0;
      if (!rst_n) begin
         hist.delete();
         m_cnt = 0; m_phase = 0; s0_v = 0; s1_v = 0;
      end else begin
         s0_v = in_valid;
         if (in_valid) begin
            int n, d, wet, dry, term;
            n = hist.size();
            d = 256 + sine_tab[m_phase];
            dry = $signed(in_sample);
            wet = (n >= d) ? hist[n - d] : 0;
            s0_mix = (dry + wet) >>> 1;
            s0_dry = dry;
            hist.push_back(dry);
            term = (int'(speed_sel) + 1) * 16 - 1;
            if (m_cnt >= term) begin
               m_cnt = 0; m_phase = (m_phase + 1) % 256; tick_now = 1'b1;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(out_valid == s1_v, "R2 out_valid", out_valid, s1_v);
         check(lfo_tick == tick_now, "R7/R8 lfo_tick", lfo_tick, tick_now);
         if (s1_v && out_valid) begin
            check($signed(out_mix) == s1_mix, "R3/R4/R5/R6 out_mix", $signed(out_mix), s1_mix);
            check($signed(out_dry) == s1_dry, "R9 out_dry", $signed(out_dry), s1_dry);
         end
      end
   end

   task automatic send(input int value, input int gap);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = 16'(value);
      @(negedge clk);
      in_valid  = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
      #0;
   endtask

   task automatic burst(input int count, input int value0, input int step);
      for (int k = 0; k < count; k++) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_sample = 16'(value0 + k * step);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin : wd
      for (int c = 0; c < WATCHDOG; c++) begin
         @(posedge clk);
         if (done) disable wd;
      end
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      speed_sel = 4'd0;
      repeat (4) @(negedge clk);
      tag = "R1 reset";
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(lfo_tick == 1'b0, "R1 lfo_tick", lfo_tick, 0);
      check(out_mix == 16'd0, "R1 out_mix", out_mix, 0);
      check(out_dry == 16'd0, "R1 out_dry", out_dry, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after release", out_valid, 0);
      check(out_mix == 16'd0, "R1 out_mix after release", out_mix, 0);

      tag = "R5 fill region";
      burst(300, 5, 37);
      tag = "R4/R6/R11 ramp sweep and wrap";
      burst(4500, 11110, 37);
      tag = "R3 full-scale";
      speed_sel = 4'd2;
      burst(700, 32767, 0);
      burst(700, -32768, 0);
      for (int k = 0; k < 400; k++) send((k % 2) ? 32767 : -32768, 0);
      tag = "R10 idle gaps";
      speed_sel = 4'd7;
      for (int k = 0; k < 800; k++) send(k * 53 - 9000, k % 4);
      tag = "R7 slow speed";
      speed_sel = 4'd15;
      burst(3000, -20000, 13);
      tag = "R7 speed drop";
      @(negedge clk);
      speed_sel = 4'd1;
      burst(600, 300, -41);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule